// File: doc/BRIEF.md
# Two-Wire Lighting Bus Frame Transceiver

This block sits between a lighting bus line and a command decoder. On the receive side it watches the bus line and checks the bi-phase bit coding. It collects a forward frame of one start bit, an address byte, a data byte and two stop bits. It then hands the two bytes to the decoder as one parallel word with a single-cycle strobe. A frame with broken coding or broken stop periods is dropped, and a single-cycle error strobe is raised instead.

On the transmit side, the decoder requests a reply and supplies one data byte. The block holds the request until the bus has been quiet for a programmable number of half-bit periods. It then drives a reply frame of one start bit, the data byte and two stop bits. All bus timing comes from a one-cycle enable, `half_tick`, that pulses twice per bit period.

The bus is a single shared line. The receiver therefore disregards the line while the block is sending its own reply.

Top module: `lbus_xcvr`

## Requirements
- R1: After reset, `tx_line` is high, `rx_valid`, `rx_err` and `tx_busy` are low, and `tx_line` stays high whenever `tx_busy` is low.
- R2: `rx_line` is sampled only in cycles with `half_tick` high, which are taken as the quarter and three-quarter points of each bit. A forward frame is a start bit (low sample then high sample), then 16 bits with the address byte first and each byte most-significant bit first, then four high stop samples. A bit whose samples go low then high is 1, and high then low is 0. In the cycle after the final stop sample, `rx_valid` is high and `rx_word` equals {address, data}.
- R3: A bit whose two samples are equal, or a start bit whose second sample is low, raises `rx_err` and drops the frame. The receiver then needs one high sample before it accepts a new start bit.
- R4: A low sample in any of the four stop half-bits raises `rx_err`, and no `rx_valid` is given for that frame.
- R5: `rx_valid` and `rx_err` are each high for one cycle only, and never both in the same cycle.
- R6: A reply frame is 22 half-bits, each held for one `half_tick` period: low, high, then for each data bit from the most significant the inverse of the bit followed by the bit, then four high half-bits. `tx_line` changes only in the cycle after a `half_tick`.
- R7: An armed reply starts on the first `half_tick` before which at least `gap_ticks` consecutive ticks have passed with the receiver idle and the line high. After a forward frame with `gap_ticks` = G, the first low half-bit appears on tick G+1 after the final stop sample.
- R8: A reply requested while a forward frame is being received does not start before that frame has completed.
- R9: A `reply_req` pulse given while `tx_busy` is high is ignored. The byte already held is the one sent, and no second reply follows.
- R10: While a reply is being sent, the receiver ignores `rx_line` and raises neither `rx_valid` nor `rx_err`.
- R11: `tx_busy` is high from the cycle after an accepted request until the cycle after the tick that ends the last stop half-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle enable at twice the bit rate |
| rx_line | input | 1 | Received bus level |
| gap_ticks | input | GAP_W | Idle half-bits required before a reply |
| reply_req | input | 1 | Pulse that arms a reply |
| reply_data | input | DATA_W | Reply byte, taken with `reply_req` |
| tx_line | output | 1 | Driven bus level, idle high |
| tx_busy | output | 1 | Reply armed or being sent |
| rx_busy | output | 1 | Forward frame being received |
| rx_word | output | ADDR_W+DATA_W | Last decoded {address, data} |
| rx_valid | output | 1 | One-cycle strobe for a good frame |
| rx_err | output | 1 | One-cycle strobe for a dropped frame |

## Verification
Two functions can meet in one clock edge. The receiver can complete a forward frame (the `rx_valid` strobe) on the same edge at which the encoder accepts a new reply request. This also falls on the edge that resets the idle gap count. The bench provokes this by asserting `reply_req` in the same cycle as the tick carrying the final stop sample, with `gap_ticks` at zero. It then judges that the word is still delivered once and that the reply's start half-bit appears on the very next tick, with the full 22-half-bit pattern after it. A second case requests the reply in the middle of a frame with a non-zero gap, and checks that the start is held back by exactly the gap.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARMED,
        TX_RUN
    } tx_state_t;

endpackage

// File: rtl/lbus_rx.sv
module lbus_rx
    import lbus_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int STOP_BITS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     line,
    output logic [ADDR_W+DATA_W-1:0] word,
    output logic                     valid,
    output logic                     err,
    output logic                     busy
);
    localparam int WORD_W      = ADDR_W + DATA_W;
    localparam int HALF_BITS   = 2 * WORD_W;
    localparam int STOP_HALVES = 2 * STOP_BITS;
    localparam int CNT_W       = $clog2(HALF_BITS + STOP_HALVES);

    typedef struct packed {
        rx_state_t          st;
        logic [CNT_W-1:0]   cnt;
        logic               first;
        logic [WORD_W-1:0]  sh;
        logic [WORD_W-1:0]  word;
        logic               valid;
        logic               err;
    } rx_reg_t;

    rx_reg_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        if (tick) begin
            unique case (q.st)
                RX_HUNT: begin
                    if (line) d.st = RX_IDLE;
                end
                RX_IDLE: begin
                    if (!line) d.st = RX_START;
                end
                RX_START: begin
                    d.cnt = '0;
                    if (line) begin
                        d.st = RX_BITS;
                    end else begin
                        d.err = 1'b1;
                        d.st  = RX_HUNT;
                    end
                end
                RX_BITS: begin
                    if (!q.cnt[0]) begin
                        d.first = line;
                        d.cnt   = q.cnt + 1'b1;
                    end else if (line == q.first) begin
                        d.err = 1'b1;
                        d.st  = RX_HUNT;
                    end else begin
                        d.sh = {q.sh[WORD_W-2:0], line};
                        if (q.cnt == CNT_W'(HALF_BITS - 1)) begin
                            d.st  = RX_STOP;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (!line) begin
                        d.err = 1'b1;
                        d.st  = RX_HUNT;
                    end else if (q.cnt == CNT_W'(STOP_HALVES - 1)) begin
                        d.valid = 1'b1;
                        d.word  = q.sh;
                        d.st    = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= RX_HUNT;
        end else begin
            q <= d;
        end
    end

    assign word  = q.word;
    assign valid = q.valid;
    assign err   = q.err;
    assign busy  = (q.st == RX_START) || (q.st == RX_BITS) || (q.st == RX_STOP);

endmodule

// File: rtl/lbus_gap.sv
module lbus_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic             rx_busy,
    input  logic             tx_run,
    input  logic [GAP_W-1:0] gap_ticks,
    output logic             gap_ok
);
    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } gap_reg_t;

    gap_reg_t q, d;

    always_comb begin
        d = q;
        if (tx_run) begin
            d.cnt = '0;
        end else if (tick) begin
            if (line && !rx_busy) begin
                if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
            end else begin
                d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign gap_ok = (q.cnt >= gap_ticks);

endmodule

// File: rtl/lbus_tx.sv
module lbus_tx
    import lbus_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int STOP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic [DATA_W-1:0] req_data,
    input  logic              go_ok,
    output logic              line,
    output logic              busy,
    output logic              run
);
    localparam int SB2    = 2 * STOP_BITS;
    localparam int HALVES = 2 + 2 * DATA_W + SB2;
    localparam int CNT_W  = $clog2(HALVES);

    typedef struct packed {
        tx_state_t          st;
        logic [DATA_W-1:0]  data;
        logic [HALVES-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic               line;
    } tx_reg_t;

    tx_reg_t q, d;
    logic [HALVES-1:0] pat;

    always_comb begin
        pat             = '1;
        pat[HALVES-1]   = 1'b0;
        pat[HALVES-2]   = 1'b1;
        for (int i = 0; i < DATA_W; i++) begin
            pat[SB2 + 2*i + 1] = ~q.data[i];
            pat[SB2 + 2*i]     =  q.data[i];
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            TX_IDLE: begin
                d.line = 1'b1;
                if (req) begin
                    d.data = req_data;
                    d.st   = TX_ARMED;
                end
            end
            TX_ARMED: begin
                if (tick && go_ok) begin
                    d.line = pat[HALVES-1];
                    d.sh   = {pat[HALVES-2:0], 1'b1};
                    d.cnt  = CNT_W'(HALVES - 1);
                    d.st   = TX_RUN;
                end
            end
            TX_RUN: begin
                if (tick) begin
                    if (q.cnt == '0) begin
                        d.line = 1'b1;
                        d.st   = TX_IDLE;
                    end else begin
                        d.line = q.sh[HALVES-1];
                        d.sh   = {q.sh[HALVES-2:0], 1'b1};
                        d.cnt  = q.cnt - 1'b1;
                    end
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line = q.line;
    assign busy = (q.st != TX_IDLE);
    assign run  = (q.st == TX_RUN);

endmodule

// File: rtl/lbus_xcvr.sv
module lbus_xcvr #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int STOP_BITS = 2,
    parameter int GAP_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     half_tick,
    input  logic                     rx_line,
    input  logic [GAP_W-1:0]         gap_ticks,
    input  logic                     reply_req,
    input  logic [DATA_W-1:0]        reply_data,
    output logic                     tx_line,
    output logic                     tx_busy,
    output logic                     rx_busy,
    output logic [ADDR_W+DATA_W-1:0] rx_word,
    output logic                     rx_valid,
    output logic                     rx_err
);
    logic tx_run;
    logic rx_seen;
    logic gap_ok;

    // own reply echoes on the shared line; hide it from the receiver
    assign rx_seen = rx_line | tx_run;

    lbus_rx #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STOP_BITS(STOP_BITS)
    ) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (half_tick),
        .line (rx_seen),
        .word (rx_word),
        .valid(rx_valid),
        .err  (rx_err),
        .busy (rx_busy)
    );

    lbus_gap #(
        .GAP_W(GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (half_tick),
        .line     (rx_seen),
        .rx_busy  (rx_busy),
        .tx_run   (tx_run),
        .gap_ticks(gap_ticks),
        .gap_ok   (gap_ok)
    );

    lbus_tx #(
        .DATA_W   (DATA_W),
        .STOP_BITS(STOP_BITS)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (half_tick),
        .req     (reply_req),
        .req_data(reply_data),
        .go_ok   (gap_ok && !rx_busy),
        .line    (tx_line),
        .busy    (tx_busy),
        .run     (tx_run)
    );

endmodule

// File: rtl/lbus_xcvr_chk.sv
module lbus_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic half_tick,
    input logic tx_line,
    input logic tx_busy,
    input logic tx_run,
    input logic rx_busy,
    input logic rx_valid,
    input logic rx_err
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_err));

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !rx_err);

    a_r6_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_line != $past(tx_line)) |-> $past(half_tick));

    a_r8_start_after_receive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_run) |-> $past(!rx_busy));

    a_r10_deaf_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        tx_run |-> (!rx_valid && !rx_err));

    a_r11_busy_covers_run: assert property (@(posedge clk) disable iff (!rst_n)
        tx_run |-> tx_busy);

endmodule

bind lbus_xcvr lbus_xcvr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_tick(half_tick),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy),
    .tx_run   (tx_run),
    .rx_busy  (rx_busy),
    .rx_valid (rx_valid),
    .rx_err   (rx_err)
);

// File: tb/lbus_xcvr_bench.sv
`timescale 1ns/1ps
module lbus_xcvr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_tick = 1'b0;
    logic        rx_line = 1'b1;
    logic [7:0]  gap_ticks = 8'd0;
    logic        reply_req = 1'b0;
    logic [7:0]  reply_data = 8'd0;
    logic        tx_line, tx_busy, rx_busy, rx_valid, rx_err;
    logic [15:0] rx_word;

    int errors = 0, total = 0;
    bit done = 0;
    logic s_tx = 1'b1;
    int seen_valid = 0, seen_err = 0, tx_low_seen = 0;
    logic [15:0] got_word = '0;
    logic req_on_tick = 1'b0;
    logic [7:0] req_data_tick = '0;

    always #2.5 clk = ~clk;

    lbus_xcvr u_lbus_xcvr (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .rx_line(rx_line),
        .gap_ticks(gap_ticks), .reply_req(reply_req), .reply_data(reply_data),
        .tx_line(tx_line), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_err(rx_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_half(input logic [7:0] d, input int i);
        logic b;
        if (i == 0) return 1'b0;
        if (i == 1) return 1'b1;
        if (i >= 18) return 1'b1;
        b = d[7 - (i - 2) / 2];
        return ((i % 2) == 0) ? ~b : b;
    endfunction

    task automatic step(input logic v);
        @(negedge clk);
        rx_line   = v;
        half_tick = 1'b1;
        reply_req = req_on_tick;
        reply_data = req_data_tick;
        @(negedge clk);
        half_tick = 1'b0;
        reply_req = 1'b0;
        req_on_tick = 1'b0;
        s_tx = tx_line;
        if (!tx_line) tx_low_seen++;
        if (rx_valid) begin seen_valid++; got_word = rx_word; end
        if (rx_err) seen_err++;
        @(negedge clk);
        if (rx_valid) seen_valid++;
        if (rx_err) seen_err++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic pulse_req(input logic [7:0] d);
        @(negedge clk);
        reply_req = 1'b1; reply_data = d;
        @(negedge clk);
        reply_req = 1'b0;
    endtask

    task automatic fstep(input logic v, input int req_at, input logic [7:0] rd, inout int h);
        if (h == req_at) begin req_on_tick = 1'b1; req_data_tick = rd; end
        step(v);
        h++;
    endtask

    task automatic send_fwd(input logic [7:0] a, input logic [7:0] dt, input int bad_bit,
                            input int bad_stop, input int req_at, input logic [7:0] rd);
        logic [15:0] w = {a, dt};
        int h = 0;
        seen_valid = 0; seen_err = 0; tx_low_seen = 0;
        fstep(1'b0, req_at, rd, h);
        fstep(1'b1, req_at, rd, h);
        for (int k = 0; k < 16; k++) begin
            logic b = w[15-k];
            if (k == bad_bit) begin
                fstep(~b, req_at, rd, h);
                fstep(~b, req_at, rd, h);
                return;
            end
            fstep(~b, req_at, rd, h);
            fstep(b, req_at, rd, h);
        end
        for (int j = 0; j < 4; j++) begin
            fstep((j == bad_stop) ? 1'b0 : 1'b1, req_at, rd, h);
            if (j == bad_stop) return;
        end
    endtask

    task automatic run_reply(input int g, input logic [7:0] d, input int ign_at,
                             output int first_low, output int mism);
        first_low = -1; mism = 0;
        seen_valid = 0; seen_err = 0;
        for (int k = 1; k <= g + 26; k++) begin
            logic e;
            step(s_tx);
            if (!s_tx && first_low < 0) first_low = k;
            e = (k <= g) ? 1'b1 : (k <= g + 22) ? exp_half(d, k - g - 1) : 1'b1;
            if (s_tx !== e) mism++;
            if (k == ign_at) pulse_req(8'hFF);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b1, "R1 tx_line after reset", tx_line, 1);
        chk(rx_valid === 1'b0 && rx_err === 1'b0, "R1 strobes after reset", {rx_valid, rx_err}, 0);
        chk(tx_busy === 1'b0, "R1 tx_busy after reset", tx_busy, 0);
        idle(3);
    endtask

    task automatic t_rx_good(input logic [7:0] a, input logic [7:0] dt);
        send_fwd(a, dt, -1, -1, -1, 8'h00);
        chk(seen_valid == 1, "R2 one valid per frame", seen_valid, 1);
        chk(got_word == {a, dt}, "R2 decoded word", got_word, {a, dt});
        chk(seen_err == 0, "R5 no error on good frame", seen_err, 0);
        idle(2);
    endtask

    task automatic t_rx_bad_bit();
        send_fwd(8'hC3, 8'h5A, 5, -1, -1, 8'h00);
        chk(seen_err == 1 && seen_valid == 0, "R3 equal halves flagged", {seen_err, seen_valid}, 16);
        idle(6);
        send_fwd(8'h11, 8'h22, -1, -1, -1, 8'h00);
        chk(seen_valid == 1 && got_word == 16'h1122, "R3 recovery after error", got_word, 16'h1122);
        idle(2);
    endtask

    task automatic t_rx_bad_stop();
        send_fwd(8'h77, 8'h88, -1, 1, -1, 8'h00);
        chk(seen_err == 1, "R4 low stop half flagged", seen_err, 1);
        chk(seen_valid == 0, "R4 no valid on bad stop", seen_valid, 0);
        idle(6);
    endtask

    task automatic t_reply_gap();
        int fl, mm;
        gap_ticks = 8'd3;
        send_fwd(8'h12, 8'h34, -1, -1, 10, 8'hC5);
        chk(tx_low_seen == 0, "R8 no reply during receive", tx_low_seen, 0);
        chk(got_word == 16'h1234 && seen_valid == 1, "R2 word with pending reply", got_word, 16'h1234);
        chk(tx_busy === 1'b1, "R11 busy while armed", tx_busy, 1);
        pulse_req(8'h0F);
        run_reply(3, 8'hC5, -1, fl, mm);
        chk(fl == 4, "R7 start tick after gap", fl, 4);
        chk(mm == 0, "R6 R9 reply pattern of first byte", mm, 0);
        chk(seen_valid == 0 && seen_err == 0, "R10 receiver deaf while sending", {seen_valid, seen_err}, 0);
        chk(tx_busy === 1'b0, "R11 busy cleared after frame", tx_busy, 0);
    endtask

    task automatic t_same_cycle();
        int fl, mm;
        gap_ticks = 8'd0;
        idle(2);
        send_fwd(8'h5A, 8'h96, -1, -1, 37, 8'h3B);
        chk(seen_valid == 1 && got_word == 16'h5A96, "R2 word with same-cycle request", got_word, 16'h5A96);
        run_reply(0, 8'h3B, 5, fl, mm);
        chk(fl == 1, "R7 zero gap starts next tick", fl, 1);
        chk(mm == 0, "R6 reply pattern zero gap", mm, 0);
        chk(tx_busy === 1'b0, "R9 request during send ignored", tx_busy, 0);
        tx_low_seen = 0;
        idle(8);
        chk(tx_low_seen == 0, "R9 no second reply", tx_low_seen, 0);
    endtask

    initial begin
        t_reset();
        t_rx_good(8'hA5, 8'h3C);
        t_rx_good(8'h00, 8'hFF);
        t_rx_good(8'h80, 8'h01);
        t_rx_bad_bit();
        t_rx_bad_stop();
        t_reply_gap();
        t_same_cycle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

endmodule